// File: doc/BRIEF.md
# Platform Interrupt Controller

The block gathers level-sensitive interrupt requests from a configurable set of sources and routes them to a small number of processor contexts. It drives one interrupt line per context. Software reaches it through a plain 32-bit register port. Each source has a priority. Each context has its own enable vector, a threshold, and a claim/complete register. A source with priority 0 never interrupts.

A source's request is latched as pending on a clock edge. A context's line rises when one of the sources it has enabled is pending with a priority strictly above the context's threshold. The handler reads the context's claim register. That read returns the winning source ID and removes the source's pending bit on the same edge. The source is then held in service and cannot pend again until software writes its ID back to a claim register. ID 0 is reserved and means "nothing to claim".

Read data is combinational and valid only in the cycle where `re_i` is high. The side effect of a claim read happens at the clock edge that ends that cycle. `re_i` and `we_i` are never asserted together, and addresses are word aligned. A misaligned address counts as unmapped.

Top module: `irq_hub`

## Requirements
- R1: After reset, every priority, threshold and enable bit is 0, no source is pending, `irq_o` is all 0, and a claim read returns 0.
- R2: The priority of source n (1..31) is at byte address 4·n. Only the low 3 bits are stored, and the upper bits read as 0. Address 0 and addresses for IDs above 31 (up to 0xFFC) are unmapped.
- R3: The enable word of context c is at 0x2000 + 0x80·c. Bit n enables source n. Bit 0 is fixed at 0 and reads as 0.
- R4: The threshold of context c is at 0x200000 + 0x1000·c, and its claim/complete register is at that address + 4. Only the low 3 bits of the threshold are stored.
- R5: `irq_o[c]` is high exactly when some pending source enabled in context c has a priority strictly greater than the threshold of c. The line follows a register write on the edge that performs the write. A source with priority 0 never raises it.
- R6: A claim read of context c returns the qualifying source with the highest priority, with ties going to the lowest ID. It returns 0 when no source qualifies. The returned source's pending bit clears at the edge that ends the read.
- R7: A claimed source does not pend again, even with its request held high, until its ID is written to a claim register. If the request is still high after the completion, the source pends again one clock after the completion edge.
- R8: A completion write has no effect when it carries an ID that is not in service, ID 0, or an ID above 31.
- R9: Reads of unmapped addresses return 0, and writes to them change no register. Unmapped addresses include enable words other than word 0 and offsets other than +0 and +4 in a context block.
- R10: A request sampled high at a clock edge makes the source pending. The pending state stays after the request line drops, until the source is claimed.
- R11: Pending state is shared by all contexts. A source enabled in both contexts raises both lines, and a claim by one context removes it from the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level request lines, bit n belongs to source n (indices NUM_SRC:1) |
| addr_i | input | ADDR_W | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe, claim side effect at the closing edge |
| rdata_o | output | 32 | Read data, valid while re_i is high, 0 otherwise |
| irq_o | output | NUM_CTX | Interrupt line per context |

## Verification
The bench aims at the arbitration corners first. Two sources share the top priority, so a design that breaks ties toward the higher ID, or compares with "greater or equal", returns the wrong order of IDs. A source whose priority equals the threshold must stay silent, and a design that gets this wrong raises `irq_o` early. A request held high across a claim would re-pend at once if the in-service hold were missing. Stray completions carrying 0, an unclaimed ID or an out-of-range ID would release that hold if completion decoding were loose. A source enabled in two contexts catches a design that keeps pending state per context, because that design lets the second context claim the source again.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned PRIO_SPAN    = 32'h1000;
  localparam int unsigned EN_BASE      = 32'h2000;
  localparam int unsigned EN_STRIDE    = 32'h80;
  localparam int unsigned CX_BASE      = 32'h200000;
  localparam int unsigned CX_STRIDE    = 32'h1000;
  localparam int unsigned CX_THR_OFF   = 32'h0;
  localparam int unsigned CX_CLAIM_OFF = 32'h4;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_PRIO,
    REG_EN,
    REG_THR,
    REG_CLAIM
  } reg_kind_e;
endpackage

// File: rtl/irq_hub_gate.sv
module irq_hub_gate #(
  parameter int NUM_SRC = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_SRC:1] src_i,
  input  logic [NUM_SRC:1] claim_i,
  input  logic [NUM_SRC:1] done_i,
  output logic [NUM_SRC:1] pend_o
);
  logic [NUM_SRC:1] pend_q;
  logic [NUM_SRC:1] busy_q;

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[s] <= 1'b0;
        busy_q[s] <= 1'b0;
      end else if (claim_i[s]) begin
        pend_q[s] <= 1'b0;
        busy_q[s] <= 1'b1;
      end else if (done_i[s] && busy_q[s]) begin
        busy_q[s] <= 1'b0;
      end else if (src_i[s] && !busy_q[s] && !pend_q[s]) begin
        pend_q[s] <= 1'b1;
      end
    end

    assert_claim_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      claim_i[s] |-> pend_q[s]);
    assert_pend_busy_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pend_q[s] && busy_q[s]));
    assert_hold_in_service_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q[s] && !done_i[s]) |=> !pend_q[s]);
    assert_pend_latched_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[s] && !claim_i[s]) |=> pend_q[s]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_hub_arb.sv
module irq_hub_arb #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 5
) (
  input  logic [NUM_SRC:1]             pend_i,
  input  logic [NUM_SRC:1]             en_i,
  input  logic [NUM_SRC:1][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]            thr_i,
  output logic [ID_W-1:0]              id_o
);
  logic [PRIO_W-1:0] best_p;

  // ascending scan with strict compare: ties keep the lower ID
  always_comb begin
    best_p = thr_i;
    id_o   = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      if (pend_i[s] && en_i[s] && (prio_i[s] > best_p)) begin
        best_p = prio_i[s];
        id_o   = ID_W'(s);
      end
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC:1]   src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [31:0]        wdata_i,
  input  logic               re_i,
  output logic [31:0]        rdata_o,
  output logic [NUM_CTX-1:0] irq_o
);
  localparam int ID_W     = $clog2(NUM_SRC + 1);
  localparam int EN_WORDS = (NUM_SRC + 32) / 32;
  localparam int EN_BITS  = EN_WORDS * 32;
  localparam int EW_W     = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

  function automatic logic [EN_BITS-1:0] en_mask_f();
    logic [EN_BITS-1:0] m;
    for (int i = 0; i < EN_BITS; i++) m[i] = (i >= 1) && (i <= NUM_SRC);
    return m;
  endfunction
  localparam logic [EN_BITS-1:0] EN_MASK = en_mask_f();

  logic [NUM_SRC:1][PRIO_W-1:0]      prio_q;
  logic [NUM_CTX-1:0][EN_BITS-1:0]   en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0]    thr_q;
  logic [NUM_CTX-1:0][ID_W-1:0]      win_id;
  logic [NUM_SRC:1]                  pend;
  logic [NUM_SRC:1]                  claim_v;
  logic [NUM_SRC:1]                  done_v;

  reg_kind_e         kind;
  logic [CTX_W-1:0]  sel_ctx;
  logic [EW_W-1:0]   sel_word;
  logic [ID_W-1:0]   sel_src;
  logic [31:0]       a, off_en, off_cx;

  assign a      = 32'(addr_i);
  assign off_en = a - EN_BASE;
  assign off_cx = a - CX_BASE;

  always_comb begin
    kind     = REG_NONE;
    sel_ctx  = '0;
    sel_word = '0;
    sel_src  = '0;
    if (a[1:0] == 2'b00) begin
      if (a < PRIO_SPAN) begin
        if (32'(a[11:2]) >= 32'd1 && 32'(a[11:2]) <= 32'(NUM_SRC)) begin
          kind    = REG_PRIO;
          sel_src = a[2 +: ID_W];
        end
      end else if (a >= EN_BASE && a < EN_BASE + EN_STRIDE * 32'(NUM_CTX)) begin
        sel_ctx = off_en[7 +: CTX_W];
        if (32'(off_en[6:2]) < 32'(EN_WORDS)) begin
          kind     = REG_EN;
          sel_word = off_en[2 +: EW_W];
        end
      end else if (a >= CX_BASE && a < CX_BASE + CX_STRIDE * 32'(NUM_CTX)) begin
        sel_ctx = off_cx[12 +: CTX_W];
        if (off_cx[11:0] == 12'(CX_THR_OFF))        kind = REG_THR;
        else if (off_cx[11:0] == 12'(CX_CLAIM_OFF)) kind = REG_CLAIM;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (we_i) begin
      case (kind)
        REG_PRIO: prio_q[sel_src] <= wdata_i[PRIO_W-1:0];
        REG_EN:   en_q[sel_ctx][{sel_word, 5'b0} +: 32] <= wdata_i & EN_MASK[{sel_word, 5'b0} +: 32];
        REG_THR:  thr_q[sel_ctx] <= wdata_i[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      case (kind)
        REG_PRIO:  rdata_o[PRIO_W-1:0] = prio_q[sel_src];
        REG_EN:    rdata_o = en_q[sel_ctx][{sel_word, 5'b0} +: 32];
        REG_THR:   rdata_o[PRIO_W-1:0] = thr_q[sel_ctx];
        REG_CLAIM: rdata_o[ID_W-1:0] = win_id[sel_ctx];
        default: ;
      endcase
    end
  end

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_hs
    assign claim_v[s] = re_i && (kind == REG_CLAIM) && (win_id[sel_ctx] == ID_W'(s));
    assign done_v[s]  = we_i && (kind == REG_CLAIM) && (wdata_i == 32'(s));
  end

  irq_hub_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .claim_i(claim_v),
    .done_i (done_v),
    .pend_o (pend)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    irq_hub_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .pend_i(pend),
      .en_i  (en_q[c][NUM_SRC:1]),
      .prio_i(prio_q),
      .thr_i (thr_q[c]),
      .id_o  (win_id[c])
    );
    assign irq_o[c] = (win_id[c] != '0);

    assert_winner_qualifies_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_id[c] != '0) |-> (pend[win_id[c]] && en_q[c][win_id[c]]
                             && (prio_q[win_id[c]] > thr_q[c])));
  end

  assert_claim_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim_v));
endmodule

// File: tb/irq_hub_bench.sv
`timescale 1ns/100ps
module irq_hub_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:1] src = '0;
  logic [23:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_hub u_irq_hub (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .re_i(re), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [23:0] a_prio(int id); return 24'(4 * id); endfunction
  function automatic logic [23:0] a_en(int c);    return 24'(32'h2000 + 32'h80 * c); endfunction
  function automatic logic [23:0] a_thr(int c);   return 24'(32'h200000 + 32'h1000 * c); endfunction
  function automatic logic [23:0] a_clm(int c);   return 24'(32'h200004 + 32'h1000 * c); endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    cyc();
    we = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    #1 d = rdata;
    cyc();
    re = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(32'(irq), 0, "R1 irq after reset");
    rd(a_prio(1), v); check(v, 0, "R1 prio reset");
    rd(a_en(0), v);   check(v, 0, "R1 enable reset");
    rd(a_thr(1), v);  check(v, 0, "R1 threshold reset");
    rd(a_clm(0), v);  check(v, 0, "R1 claim empty");
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(a_prio(5), 32'hFFFF_FFFF);
    rd(a_prio(5), v); check(v, 7, "R2 prio low bits only");
    wr(a_prio(0), 32'h5);
    rd(a_prio(0), v); check(v, 0, "R2 id 0 unmapped");
    wr(a_prio(40), 32'h5);
    rd(a_prio(40), v); check(v, 0, "R2 id 40 unmapped");
    wr(a_en(1), 32'hFFFF_FFFF);
    rd(a_en(1), v); check(v, 32'hFFFF_FFFE, "R3 enable bit 0 fixed");
    rd(a_en(0), v); check(v, 0, "R3 contexts separate");
    wr(a_thr(1), 32'hFF);
    rd(a_thr(1), v); check(v, 7, "R4 threshold low bits only");
    wr(24'h2004, 32'hFFFF_FFFF);
    rd(24'h2004, v); check(v, 0, "R9 unmapped enable word reads 0");
    rd(a_en(0), v);  check(v, 0, "R9 unmapped write left enable alone");
    wr(24'h200008, 32'h7);
    rd(24'h200008, v); check(v, 0, "R9 unmapped context offset");
    rd(a_thr(0), v);   check(v, 0, "R9 threshold untouched");
    wr(a_en(1), 0); wr(a_thr(1), 0); wr(a_prio(5), 0);
  endtask

  task automatic t_arb();
    logic [31:0] v;
    wr(a_prio(3), 2); wr(a_prio(5), 6); wr(a_prio(7), 6);
    wr(a_en(0), 32'hA8);
    src[3] = 1'b1; src[5] = 1'b1; src[7] = 1'b1;
    cyc();
    src[3] = 1'b0; src[5] = 1'b0; src[7] = 1'b0;
    cyc();
    check(32'(irq[0]), 1, "R10 pending latched after pulse");
    check(32'(irq[1]), 0, "R11 ctx1 not enabled");
    rd(a_clm(0), v); check(v, 5, "R6 tie goes to lower id");
    rd(a_clm(0), v); check(v, 7, "R6 second of tie");
    rd(a_clm(0), v); check(v, 3, "R6 lower priority last");
    rd(a_clm(0), v); check(v, 0, "R6 nothing left");
    check(32'(irq[0]), 0, "R5 line drops when drained");
    wr(a_clm(0), 3); wr(a_clm(0), 5); wr(a_clm(0), 7);
    wr(a_en(0), 0);
  endtask

  task automatic t_thresh();
    logic [31:0] v;
    wr(a_prio(4), 3); wr(a_en(0), 32'h10); wr(a_thr(0), 3);
    src[4] = 1'b1;
    cyc();
    check(32'(irq[0]), 0, "R5 equal to threshold is silent");
    rd(a_clm(0), v); check(v, 0, "R5 claim empty at threshold");
    wr(a_thr(0), 2);
    check(32'(irq[0]), 1, "R5 line rises after threshold write");
    rd(a_clm(0), v); check(v, 4, "R6 claim returns source");
    check(32'(irq[0]), 0, "R7 claimed source not pending");
    cyc();
    check(32'(irq[0]), 0, "R7 held high, still blocked");
    wr(a_clm(0), 9); cyc();
    check(32'(irq[0]), 0, "R8 unclaimed id ignored");
    wr(a_clm(0), 0); wr(a_clm(0), 40); cyc();
    check(32'(irq[0]), 0, "R8 id 0 and out-of-range ignored");
    wr(a_clm(0), 4); cyc();
    check(32'(irq[0]), 1, "R7 re-pends after completion");
    rd(a_clm(0), v); check(v, 4, "R7 reclaim");
    src[4] = 1'b0;
    wr(a_clm(0), 4); cyc();
    check(32'(irq[0]), 0, "R7 no re-pend with line low");
    wr(a_thr(0), 0); wr(a_prio(6), 0); wr(a_en(0), 32'h40);
    src[6] = 1'b1; cyc(); src[6] = 1'b0; cyc();
    check(32'(irq[0]), 0, "R5 priority 0 never interrupts");
    rd(a_clm(0), v); check(v, 0, "R5 priority 0 not claimable");
    wr(a_prio(6), 1);
    check(32'(irq[0]), 1, "R10 pending kept while priority 0");
    rd(a_clm(0), v); check(v, 6, "R6 claim after priority raise");
    wr(a_clm(0), 6); wr(a_en(0), 0);
  endtask

  task automatic t_ctx();
    logic [31:0] v;
    wr(a_prio(9), 4); wr(a_en(0), 32'h200); wr(a_en(1), 32'h200);
    src[9] = 1'b1; cyc(); src[9] = 1'b0; cyc();
    check(32'(irq), 3, "R11 both lines raised");
    rd(a_clm(1), v); check(v, 9, "R11 ctx1 claims");
    check(32'(irq), 0, "R11 claim clears both contexts");
    rd(a_clm(0), v); check(v, 0, "R11 ctx0 sees nothing");
    wr(a_clm(1), 9);
    wr(a_en(0), 0); wr(a_en(1), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_arb();
    t_thresh();
    t_ctx();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule